// File: doc/BRIEF.md
# Three-Wire Framed Register Slave

This block is a serial slave that lets a host read and write a bank of four small registers. The host uses a serial clock, an active-low select line and one data line toward the block. Each transaction while the select is held low is a fixed 24-bit frame. The frame carries an 8-bit command header, then an 8-bit register address, then an 8-bit data byte, each field sent most significant bit first. The last header bit chooses the operation. A 0 in that bit writes the data byte into the addressed register. A 1 in that bit makes the block return the register contents on its serial output during the data byte.

The serial pins are asynchronous to the block's system clock. They pass through a synchronizer, and the block finds the serial clock edges by oversampling. The host must hold each serial clock level for at least four system clock cycles. The register bank is also presented in parallel for the logic that uses it. This interface carries no stream data, so it has no valid/ready handshake and no back-pressure: a frame is accepted at the rate the host clocks it. The registers are always visible.

Top module: `ser3w_reg_slave`

## Requirements
- R1: After reset all four registers read 0x00, and both `sdo` and `sdo_en` are low.
- R2: In a frame whose eighth header bit is 0, the data byte (first bit = bit 7) is written into the register selected by address bits 1:0. Address bit 0 is the last address bit sent.
- R3: The first seven header bits have no effect. A header of 0xFE writes exactly as a header of 0x00 does, and a header of 0xFF reads exactly as a header of 0x01 does.
- R4: Address bits 7:2 have no effect on which register is selected.
- R5: In a frame whose eighth header bit is 1, `sdo` carries the selected register's bits 7 down to 0, one per data-bit period. Each bit changes after the falling serial clock edge that begins its period, so the host can sample it on the rising edge.
- R6: `sdo_en` is high only during the eight data-bit periods of a read frame. It drops on the falling edge after the last data bit or when the select rises. `sdo` is low whenever `sdo_en` is low.
- R7: A read frame leaves every register unchanged.
- R8: A frame that ends by the select rising before 24 bits have arrived changes no register.
- R9: A write is applied on the 24th rising serial clock edge. The register already holds the new value before the select rises, and it does not hold it after only 23 edges.
- R10: Serial clock edges after the 24th within the same frame are ignored. They do not change the written value and they do not drive `sdo_en`.
- R11: While the select is high, serial clock activity changes no register and leaves `sdo_en` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock from the host, idle high |
| cs_n | input | 1 | Active-low frame select |
| sdi | input | 1 | Serial data from the host |
| sdo | output | 1 | Serial read data toward the host |
| sdo_en | output | 1 | High while `sdo` carries valid read data |
| regs_o | output | 32 | Parallel register view, register n in bits 8n+7:8n |

## Verification
The bench probes the frame boundaries. It aborts frames at 20 and 23 bits: a counter that commits early, or that keeps a partial frame, would corrupt a register there. It checks the register after the 23rd and again after the 24th edge, which catches a write that lands one bit early or only when the select rises. It sends headers with all reserved bits set and addresses with high bits set, which exposes a decoder that reads the wrong header bit or too many address bits. It adds extra clocks past bit 24 and aborts a read midway, so an output enable that lingers or a shift that keeps running shows up on `sdo_en` and in the written value.

// File: rtl/ser3w_pkg.sv
package ser3w_pkg;
  typedef enum logic {
    OP_WRITE = 1'b0,
    OP_READ  = 1'b1
  } op_e;
endpackage

// File: rtl/ser3w_sync.sv
module ser3w_sync #(
  parameter int          W       = 3,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= RST_VAL;
    end else begin
      stage_q[0] <= d_async;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/ser3w_frame.sv
module ser3w_frame
  import ser3w_pkg::*;
#(
  parameter int HDR_W  = 8,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int SEL_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_s,
  input  logic              csn_s,
  input  logic              sdi_s,
  input  logic [DATA_W-1:0] rd_data,
  output logic [SEL_W-1:0]  sel,
  output logic              wr_en,
  output logic [DATA_W-1:0] wr_data,
  output logic              sdo,
  output logic              sdo_en
);
  localparam int FRAME_LEN  = HDR_W + ADDR_W + DATA_W;
  localparam int DATA_START = HDR_W + ADDR_W;
  localparam int CNT_W      = $clog2(FRAME_LEN + 1);

  logic              sclk_q;
  logic              rise, fall;
  logic [CNT_W-1:0]  bitcnt_q;
  logic [DATA_W-1:0] shift_q, next_shift, rd_shift_q;
  logic [SEL_W-1:0]  sel_q;
  op_e               op_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_q <= 1'b1;
    else        sclk_q <= sclk_s;
  end

  assign rise       = sclk_s & ~sclk_q & ~csn_s;
  assign fall       = ~sclk_s & sclk_q & ~csn_s;
  assign next_shift = {shift_q[DATA_W-2:0], sdi_s};

  // Input side: count bits and capture the operation and register select
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bitcnt_q <= '0;
      shift_q  <= '0;
      sel_q    <= '0;
      op_q     <= OP_WRITE;
    end else if (csn_s) begin
      bitcnt_q <= '0;
      sel_q    <= '0;
      op_q     <= OP_WRITE;
    end else if (rise && (bitcnt_q < CNT_W'(FRAME_LEN))) begin
      bitcnt_q <= bitcnt_q + 1'b1;
      shift_q  <= next_shift;
      if (bitcnt_q == CNT_W'(HDR_W - 1))      op_q  <= op_e'(sdi_s);
      if (bitcnt_q == CNT_W'(DATA_START - 1)) sel_q <= next_shift[SEL_W-1:0];
    end
  end

  assign sel     = sel_q;
  assign wr_data = next_shift;
  assign wr_en   = rise && (bitcnt_q == CNT_W'(FRAME_LEN - 1)) && (op_q == OP_WRITE);

  // Output side: launch read bits on falling edges during the data byte
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sdo        <= 1'b0;
      sdo_en     <= 1'b0;
      rd_shift_q <= '0;
    end else if (csn_s) begin
      sdo        <= 1'b0;
      sdo_en     <= 1'b0;
      rd_shift_q <= '0;
    end else if (fall) begin
      if (op_q == OP_READ && bitcnt_q == CNT_W'(DATA_START)) begin
        sdo        <= rd_data[DATA_W-1];
        sdo_en     <= 1'b1;
        rd_shift_q <= {rd_data[DATA_W-2:0], 1'b0};
      end else if (op_q == OP_READ && bitcnt_q > CNT_W'(DATA_START) &&
                   bitcnt_q < CNT_W'(FRAME_LEN)) begin
        sdo        <= rd_shift_q[DATA_W-1];
        sdo_en     <= 1'b1;
        rd_shift_q <= {rd_shift_q[DATA_W-2:0], 1'b0};
      end else begin
        sdo    <= 1'b0;
        sdo_en <= 1'b0;
      end
    end
  end

  // R6
  sdo_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sdo_en |-> !sdo);
  // R6
  sdo_read_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sdo_en |-> (op_q == OP_READ));
  // R10
  bitcnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bitcnt_q <= CNT_W'(FRAME_LEN));
  // R11
  idle_count_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    csn_s |=> (bitcnt_q == '0) && !sdo_en);
endmodule

// File: rtl/ser3w_regfile.sv
module ser3w_regfile #(
  parameter int DATA_W = 8,
  parameter int SEL_W  = 2,
  localparam int NUM_REGS = 1 << SEL_W
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [SEL_W-1:0]           sel,
  input  logic [DATA_W-1:0]          wr_data,
  output logic [DATA_W-1:0]          rd_data,
  output logic [NUM_REGS*DATA_W-1:0] regs_flat
);
  logic [NUM_REGS-1:0][DATA_W-1:0] regs_q;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                           regs_q[i] <= '0;
      else if (wr_en && sel == SEL_W'(i))   regs_q[i] <= wr_data;
    end
    assign regs_flat[i*DATA_W +: DATA_W] = regs_q[i];
  end

  assign rd_data = regs_q[sel];

  // R7
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(regs_q));
  // R2
  write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> regs_q[$past(sel)] == $past(wr_data));
endmodule

// File: rtl/ser3w_reg_slave.sv
module ser3w_reg_slave #(
  parameter int HDR_W       = 8,
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 8,
  parameter int SEL_W       = 2,
  parameter int SYNC_STAGES = 2,
  localparam int NUM_REGS   = 1 << SEL_W
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       sclk,
  input  logic                       cs_n,
  input  logic                       sdi,
  output logic                       sdo,
  output logic                       sdo_en,
  output logic [NUM_REGS*DATA_W-1:0] regs_o
);
  logic [2:0]        pins_s;
  logic [SEL_W-1:0]  sel;
  logic              wr_en;
  logic [DATA_W-1:0] wr_data, rd_data;

  ser3w_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b110)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async({cs_n, sclk, sdi}), .q(pins_s)
  );

  ser3w_frame #(.HDR_W(HDR_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEL_W(SEL_W)) u_frame (
    .clk(clk), .rst_n(rst_n),
    .sclk_s(pins_s[1]), .csn_s(pins_s[2]), .sdi_s(pins_s[0]),
    .rd_data(rd_data), .sel(sel), .wr_en(wr_en), .wr_data(wr_data),
    .sdo(sdo), .sdo_en(sdo_en)
  );

  ser3w_regfile #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .sel(sel),
    .wr_data(wr_data), .rd_data(rd_data), .regs_flat(regs_o)
  );
endmodule

// File: tb/ser3w_reg_slave_test.sv
module ser3w_reg_slave_test;
  localparam int H = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sclk = 1'b1;
  logic        cs_n = 1'b1;
  logic        sdi = 1'b0;
  logic        sdo, sdo_en;
  logic [31:0] regs_o;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [7:0] model [4] = '{default: 8'h00};

  always #2 clk = ~clk;

  ser3w_reg_slave uut (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .sdi(sdi),
    .sdo(sdo), .sdo_en(sdo_en), .regs_o(regs_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_model(input string req);
    for (int i = 0; i < 4; i++) check(req, {24'h0, regs_o[i*8 +: 8]}, {24'h0, model[i]});
  endtask

  // One bit period: falling edge, settle, check output, rising edge
  task automatic clock_bit(input logic b, input int idx, input bit rd, input logic [7:0] rv);
    logic exp_en;
    @(negedge clk);
    sclk = 1'b0;
    sdi  = b;
    wait_n(H - 1);
    exp_en = rd && idx >= 16 && idx < 24;
    check("R6 sdo_en", {31'h0, sdo_en}, {31'h0, exp_en});
    if (exp_en) check("R5 sdo bit", {31'h0, sdo}, {31'h0, rv[23 - idx]});
    else        check("R6 sdo idle", {31'h0, sdo}, 32'h0);
    sclk = 1'b1;
    wait_n(H);
  endtask

  task automatic frame(input logic [7:0] hdr, input logic [7:0] addr, input logic [7:0] data,
                       input int nbits, input logic [7:0] rv);
    logic [23:0] f;
    f = {hdr, addr, data};
    @(negedge clk);
    cs_n = 1'b0;
    wait_n(H);
    for (int i = 0; i < nbits; i++)
      clock_bit(i < 24 ? f[23 - i] : 1'b1, i, hdr[0], rv);
  endtask

  task automatic end_frame();
    @(negedge clk);
    cs_n = 1'b1;
    wait_n(H);
    check("R6 release", {31'h0, sdo_en}, 32'h0);
  endtask

  task automatic t_reset();
    check_model("R1 reset regs");
    check("R1 reset sdo_en", {31'h0, sdo_en}, 32'h0);
    check("R1 reset sdo", {31'h0, sdo}, 32'h0);
  endtask

  task automatic t_write_basic();
    frame(8'h00, 8'h01, 8'hA5, 24, 8'h00);
    model[1] = 8'hA5;
    check_model("R2 write");
    end_frame();
    frame(8'h00, 8'h00, 8'h17, 24, 8'h00);
    model[0] = 8'h17;
    end_frame();
    check_model("R2 write reg0");
  endtask

  task automatic t_write_timing();
    frame(8'h00, 8'h02, 8'hC3, 23, 8'h00);
    check_model("R9 not after 23");
    clock_bit(1'b1, 23, 1'b0, 8'h00);
    model[2] = 8'hC3;
    check_model("R9 applied at 24");
    end_frame();
  endtask

  task automatic t_reserved();
    frame(8'hFE, 8'h02, 8'h3C, 24, 8'h00);
    end_frame();
    model[2] = 8'h3C;
    check_model("R3 reserved header write");
    frame(8'hFF, 8'h02, 8'h00, 24, model[2]);
    end_frame();
    check_model("R3 reserved header read");
  endtask

  task automatic t_upper_addr();
    frame(8'h00, 8'hFF, 8'h81, 24, 8'h00);
    end_frame();
    model[3] = 8'h81;
    frame(8'h00, 8'h7C, 8'h42, 24, 8'h00);
    end_frame();
    model[0] = 8'h42;
    check_model("R4 upper address bits");
  endtask

  task automatic t_read();
    frame(8'h01, 8'hA1, 8'hFF, 24, model[1]);
    end_frame();
    frame(8'h01, 8'h03, 8'h00, 24, model[3]);
    end_frame();
    frame(8'h01, 8'h54, 8'h55, 24, model[0]);
    end_frame();
    check_model("R7 read leaves regs");
  endtask

  task automatic t_abort();
    frame(8'h00, 8'h00, 8'hFF, 20, 8'h00);
    end_frame();
    frame(8'h00, 8'h01, 8'h00, 23, 8'h00);
    end_frame();
    check_model("R8 aborted frames");
    frame(8'h01, 8'h02, 8'h00, 20, model[2]);
    end_frame();
    check_model("R8 aborted read");
  endtask

  task automatic t_extra();
    frame(8'h00, 8'h01, 8'h5A, 32, 8'h00);
    end_frame();
    model[1] = 8'h5A;
    check_model("R10 extra bits on write");
    frame(8'h01, 8'h01, 8'h00, 30, model[1]);
    end_frame();
    check_model("R10 extra bits on read");
  endtask

  task automatic t_idle();
    sdi = 1'b1;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk); sclk = 1'b0; wait_n(H);
      check("R11 idle sdo_en", {31'h0, sdo_en}, 32'h0);
      sclk = 1'b1; wait_n(H);
    end
    check_model("R11 idle clocks");
    frame(8'h00, 8'h03, 8'h99, 24, 8'h00);
    end_frame();
    model[3] = 8'h99;
    check_model("R11 frame after idle clocks");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    wait_n(5);
    t_reset();
    rst_n = 1'b1;
    wait_n(5);
    t_reset();
    t_write_basic();
    t_write_timing();
    t_reserved();
    t_upper_addr();
    t_read();
    t_abort();
    t_extra();
    t_idle();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule